// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a clock-synchronous, single-port SRAM model. It has a parameterised depth and a 32-bit word made of four 8-bit byte lanes. A new address enters through one of two active-low address strobes. One strobe serves a processor and the other a controller. Three chip enables qualify the access: a master enable, a second enable that is active high and a third that is active low. Once an address is loaded, an active-low advance input walks through the aligned four-word group that contains it. The walk follows linear order or interleaved order, chosen by a static order-select pin. That pin should be tied high when no choice is made.

Writes use a global write enable that writes the whole word. A byte write enable gates four per-lane strobes. Read data is registered, so it appears one clock after the address or advance edge. An asynchronous output enable, together with the read state, gates a drive-enable flag. The data bus is held at zero whenever it is not driven.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, the drive-enable output `dout_oe` is 0 and `dout` is 0.
- R2: A strobe edge with the master enable low, `cs_hi` high and `cs_lo_n` low loads `addr`. If the cycle is a read, the word at that address appears on `dout` with `dout_oe` = 1 after that same edge, one clock after the address was presented.
- R3: `proc_strb_n` has no effect while `cs_main_n` is high. With the controller strobe and the advance input both high, the previous read data and drive state are kept.
- R4: A load with any chip enable inactive puts the device in standby. Outputs are not driven, and advance pulses access nothing until the next selecting load.
- R5: When both strobes are low in one cycle, the processor strobe's rules apply. With `cs_main_n` high, that cycle deselects. With `cs_main_n` low, it loads like a normal access.
- R6: With `order_sel` = 0 (linear), each advance cycle with no strobe accesses offset (start + n) mod 4 inside the aligned group. The upper address bits are kept.
- R7: With `order_sel` = 1 (interleaved), advance cycle n accesses offset start XOR n. Advance works for writes as well as reads.
- R8: `gw_n` = 0 writes all four lanes, whatever `bw_n` and `lane_n` are.
- R9: With `gw_n` = 1 and `bw_n` = 0, lane i (bits 8i+7:8i of `din`) is written only when `lane_n[i]` = 0. The other lanes keep their contents.
- R10: With `gw_n` = 1 and `bw_n` = 1, the cycle is a read whatever `lane_n` is. Memory is unchanged.
- R11: `oe_n` acts without a clock. When it is high, `dout_oe` is 0 and `dout` is 0. When it is low during a read state, the read word is driven.
- R12: After a write access, `dout_oe` is 0.
- R13: A cycle with both strobes high and `adv_n` high performs no access. Output data and drive state hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | ADDR_W | Word address, sampled on load |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| cs_main_n | input | 1 | Master chip enable, active low |
| cs_hi | input | 1 | Secondary chip enable, active high |
| cs_lo_n | input | 1 | Secondary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte write enable, active low |
| lane_n | input | 4 | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, zero when not driven |
| dout_oe | output | 1 | Data bus drive enable |

## Verification
Two functions that can land on one edge get the most attention. The first is a strobe load overlapping the burst advance. The second is the processor strobe overlapping the controller strobe. The bench drives `adv_n` low together with strobes, and drives both strobes together with the master enable active and inactive. It then judges the outcome from the word returned after the edge against a model of which address and which enable set should have won. Byte-lane and read-versus-write decode are judged by writing known patterns and reading them back.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int BURST_W = 2;
    localparam int GROUP   = 1 << BURST_W;

    typedef struct packed {
        logic active;
        logic rd;
    } ctl_st_t;
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] acc_addr
);
    localparam int BASE_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [BASE_W-1:0]  base;
        logic [BURST_W-1:0] start;
        logic [BURST_W-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [BURST_W-1:0] low;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base  = ld_addr[ADDR_W-1:BURST_W];
            st_d.start = ld_addr[BURST_W-1:0];
            st_d.cnt   = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        low      = order_sel ? (st_d.start ^ st_d.cnt) : (st_d.start + st_d.cnt);
        acc_addr = {st_d.base, low};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (st_q.cnt == $past(st_q.cnt) + 2'd1));

    // R2
    load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cnt == '0 && st_q.base == $past(ld_addr[ADDR_W-1:BURST_W])));
endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we,
    output logic             is_write
);
    always_comb begin
        if (!gw_n)      lane_we = '1;
        else if (!bw_n) lane_we = ~lane_n;
        else            lane_we = '0;
        is_write = |lane_we;
    end

    // R8
    global_all_chk: assert final (gw_n || (&lane_we));
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata_q   <= mem[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              cs_main_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bw_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              oe_n,
    input  logic              order_sel,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe
);
    ctl_st_t st_d, st_q;

    logic              proc_load, ctrl_load, load, sel, step, access;
    logic              is_write;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [WORD_W-1:0] rdata;

    always_comb begin
        proc_load = !proc_strb_n && !cs_main_n;
        ctrl_load = !ctrl_strb_n && !proc_load && proc_strb_n;
        if (!proc_strb_n && cs_main_n) ctrl_load = 1'b0;
        load   = proc_load || ctrl_load || (!proc_strb_n && !ctrl_strb_n);
        sel    = !cs_main_n && cs_hi && !cs_lo_n;
        step   = !load && !adv_n && st_q.active;
        access = (load && sel) || step;

        st_d = st_q;
        if (load) st_d.active = sel;
        if (access)    st_d.rd = !is_write;
        else if (load) st_d.rd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .order_sel(order_sel),
        .ld_addr  (addr),
        .acc_addr (acc_addr)
    );

    sram_wr_decode #(.LANES(LANES)) u_wdec (
        .gw_n    (gw_n),
        .bw_n    (bw_n),
        .lane_n  (lane_n),
        .lane_we (lane_we),
        .is_write(is_write)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
            .clk  (clk),
            .we   (access && lane_we[g]),
            .re   (access && !is_write),
            .addr (acc_addr),
            .wdata(din[g*LANE_W +: LANE_W]),
            .rdata(rdata[g*LANE_W +: LANE_W])
        );
    end

    assign dout_oe = !oe_n && st_q.rd;
    assign dout    = dout_oe ? rdata : '0;

    // R3
    proc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && cs_main_n && ctrl_strb_n && adv_n) |=> ($stable(st_q) && $stable(rdata)));

    // R4
    standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !sel) |=> (!st_q.active && !dout_oe));

    // R12
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && is_write) |=> !dout_oe);

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strb_n && ctrl_strb_n && adv_n) |=> ($stable(rdata) && $stable(st_q)));
endmodule

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        proc_strb_n = 1'b1, ctrl_strb_n = 1'b1, cs_main_n = 1'b0;
    logic        cs_hi = 1'b1, cs_lo_n = 1'b0, adv_n = 1'b1;
    logic        gw_n = 1'b1, bw_n = 1'b1;
    logic [3:0]  lane_n = 4'hF;
    logic        oe_n = 1'b0, order_sel = 1'b1;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        dout_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sync_burst_sram dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
        .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .adv_n(adv_n), .gw_n(gw_n), .bw_n(bw_n), .lane_n(lane_n),
        .oe_n(oe_n), .order_sel(order_sel), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        ps_n, cs_n, mm_n, hi, lo_n, av_n, g_n, b_n;
        logic [3:0]  ln;
        logic [7:0]  a;
        logic [31:0] d;
        logic        e_oe;
        logic [31:0] e_d;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        // R8 R12: global write at 0x10
        {4'd8,  8'b1_0_0_1_0_1_0_1, 4'hF, 8'h10, 32'hAABBCCDD, 1'b0, 32'h0},
        // R2: controller read
        {4'd2,  8'b1_0_0_1_0_1_1_1, 4'hF, 8'h10, 32'h0, 1'b1, 32'hAABBCCDD},
        // R9: lanes 0 and 2 written
        {4'd9,  8'b0_1_0_1_0_1_1_0, 4'hA, 8'h10, 32'h11223344, 1'b0, 32'h0},
        // R9: processor read back
        {4'd9,  8'b0_1_0_1_0_1_1_1, 4'hF, 8'h10, 32'h0, 1'b1, 32'hAA22CC44},
        // R10: lane strobes without byte enable read
        {4'd10, 8'b1_0_0_1_0_1_1_1, 4'h0, 8'h10, 32'hFFFFFFFF, 1'b1, 32'hAA22CC44},
        // R8: global write overrides idle lane strobes
        {4'd8,  8'b1_0_0_1_0_1_0_1, 4'hF, 8'h11, 32'h01020304, 1'b0, 32'h0},
        // R8: read back
        {4'd8,  8'b1_0_0_1_0_1_1_1, 4'hF, 8'h11, 32'h0, 1'b1, 32'h01020304},
        // R3 R13: blocked processor strobe holds
        {4'd3,  8'b0_1_1_1_0_1_1_1, 4'hF, 8'h10, 32'h0, 1'b1, 32'h01020304},
        // R4: deselecting load
        {4'd4,  8'b1_0_0_0_0_1_1_1, 4'hF, 8'h10, 32'h0, 1'b0, 32'h0},
        // R4: advance in standby
        {4'd4,  8'b1_1_1_1_0_0_1_1, 4'hF, 8'h10, 32'h0, 1'b0, 32'h0},
        // R2: read confirms R10 left memory unchanged
        {4'd2,  8'b1_0_0_1_0_1_1_1, 4'hF, 8'h10, 32'h0, 1'b1, 32'hAA22CC44},
        // R5: both strobes, master inactive
        {4'd5,  8'b0_0_1_1_0_1_1_1, 4'hF, 8'h11, 32'h0, 1'b0, 32'h0},
        // R5: both strobes, master active
        {4'd5,  8'b0_0_0_1_0_1_1_1, 4'hF, 8'h11, 32'h0, 1'b1, 32'h01020304}
    };

    task automatic chk(input string req, input logic a_oe, input logic [31:0] a_d,
                       input logic e_oe, input logic [31:0] e_d);
        n_chk++;
        if (a_oe !== e_oe || a_d !== e_d) begin
            n_fail++;
            $display("FAIL %s: oe=%0b dout=%08h expected oe=%0b dout=%08h",
                     req, a_oe, a_d, e_oe, e_d);
        end
    endtask

    task automatic idle();
        proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bw_n = 1'b1; lane_n = 4'hF;
    endtask

    task automatic ctrl_acc(input logic [7:0] a, input logic wr, input logic [31:0] d);
        idle();
        cs_main_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
        ctrl_strb_n = 1'b0; addr = a; gw_n = !wr; din = d;
        @(negedge clk);
    endtask

    task automatic adv_acc(input logic wr, input logic [31:0] d);
        idle();
        adv_n = 1'b0; gw_n = !wr; din = d;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: oe=%0b dout=%08h expected run to end", dout_oe, dout);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", dout_oe, dout, 1'b0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", dout_oe, dout, 1'b0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            {proc_strb_n, ctrl_strb_n, cs_main_n, cs_hi, cs_lo_n, adv_n, gw_n, bw_n}
                = {VEC[i].ps_n, VEC[i].cs_n, VEC[i].mm_n, VEC[i].hi,
                   VEC[i].lo_n, VEC[i].av_n, VEC[i].g_n, VEC[i].b_n};
            lane_n = VEC[i].ln; addr = VEC[i].a; din = VEC[i].d;
            @(negedge clk);
            chk($sformatf("R%0d vec%0d", VEC[i].req, i), dout_oe, dout, VEC[i].e_oe, VEC[i].e_d);
        end

        // fill group 0x20..0x23
        for (int i = 0; i < 4; i++) ctrl_acc(8'h20 + 8'(i), 1'b1, 32'hB000_0000 + i);

        // R6: linear burst from offset 2 wraps 2,3,0,1
        order_sel = 1'b0;
        ctrl_acc(8'h22, 1'b0, 32'h0);
        chk("R6 start", dout_oe, dout, 1'b1, 32'hB000_0002);
        adv_acc(1'b0, 32'h0); chk("R6 beat1", dout_oe, dout, 1'b1, 32'hB000_0003);
        adv_acc(1'b0, 32'h0); chk("R6 beat2", dout_oe, dout, 1'b1, 32'hB000_0000);
        adv_acc(1'b0, 32'h0); chk("R6 beat3", dout_oe, dout, 1'b1, 32'hB000_0001);

        // R13: idle cycles hold read data
        idle(); @(negedge clk);
        chk("R13 hold", dout_oe, dout, 1'b1, 32'hB000_0001);

        // R7: interleaved burst from offset 1 gives 1,0,3,2
        order_sel = 1'b1;
        ctrl_acc(8'h21, 1'b0, 32'h0);
        chk("R7 start", dout_oe, dout, 1'b1, 32'hB000_0001);
        adv_acc(1'b0, 32'h0); chk("R7 beat1", dout_oe, dout, 1'b1, 32'hB000_0000);
        adv_acc(1'b0, 32'h0); chk("R7 beat2", dout_oe, dout, 1'b1, 32'hB000_0003);
        adv_acc(1'b0, 32'h0); chk("R7 beat3", dout_oe, dout, 1'b1, 32'hB000_0002);

        // R2: strobe wins over a simultaneous advance
        idle(); cs_main_n = 1'b0; ctrl_strb_n = 1'b0; adv_n = 1'b0; addr = 8'h20;
        @(negedge clk);
        chk("R2 load beats adv", dout_oe, dout, 1'b1, 32'hB000_0000);

        // R7: interleaved write burst from 0x27 -> 0x27,0x26,0x25,0x24
        ctrl_acc(8'h27, 1'b1, 32'hC000_0000);
        chk("R12 burst write", dout_oe, dout, 1'b0, 32'h0);
        adv_acc(1'b1, 32'hC000_0001);
        adv_acc(1'b1, 32'hC000_0002);
        adv_acc(1'b1, 32'hC000_0003);
        for (int i = 0; i < 4; i++) begin
            ctrl_acc(8'h27 - 8'(i), 1'b0, 32'h0);
            chk("R7 write burst", dout_oe, dout, 1'b1, 32'hC000_0000 + i);
        end

        // R11: output enable without a clock edge
        oe_n = 1'b1; #0.5;
        chk("R11 off", dout_oe, dout, 1'b0, 32'h0);
        oe_n = 1'b0; #0.5;
        chk("R11 on", dout_oe, dout, 1'b1, 32'hC000_0003);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule